// File: doc/BRIEF.md
# Byte-Wide SPI Host with Register Access

This block is a memory-mapped SPI host. Software reaches its registers over a simple 32-bit register bus. A byte written to the transmit register starts one full-duplex 8-bit exchange. The byte clocked in during that exchange waits in the receive register until software reads it. Software drives the chip-select line itself, through a bit in the system register.

The serial clock comes from a two-stage divider. A prescaler divides the bus clock by one of two factors, chosen by a control bit. A second stage divides the result again by (n+1)*2, where n is a 5-bit field. Two other control bits select the idle level of the clock and the edge on which data is sampled, so all four SPI modes are available. Data moves most significant bit first.

Software sets up the divider and mode, enables the block with chip select asserted, and writes a byte. It polls the busy flag, then reads the received byte, which clears the receive-full flag.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, every register reads 0, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0 and no exchange is in progress.
- R2: The registers sit at these byte offsets: control 0x00 (8 bits), status 0x04, system 0x08 (8 bits), transmit 0x0C (8 bits), receive 0x10 (8 bits) and spare control 0x14 (32 bits). Control, system and spare control read back what was written, truncated to their widths. Transmit reads back the last byte accepted. Every other offset reads 0.
- R3: One half-period of SCK lasts P*(n+1) bus clocks. n is control bits 4:0. P is PRE_LO when control bit 5 is 0 and PRE_HI when it is 1. The defaults are 16 and 128.
- R4: Control bit 6 (CPOL) sets the level at which SCK rests. Control bit 7 (CPHA) selects the edges. With CPHA 0, data is sampled on the leading edge of each clock pulse and MOSI changes on the trailing edge. With CPHA 1, MOSI changes on the leading edge and data is sampled on the trailing edge.
- R5: Each exchange has exactly 16 SCK edges and sends the transmit byte MSB first. The byte sampled from MISO, first bit as MSB, then appears in bits 7:0 of the receive register.
- R6: Status bit 0 (busy) reads 1 from the clock after an accepted transmit write until the 16th SCK edge, and 0 otherwise.
- R7: Status bit 2 (receive full) becomes 1 in the cycle in which busy falls. It clears when the receive register is read, or when the status register is written with bit 2 at 0. The received byte is kept in either case.
- R8: A transmit write while busy is 1 is ignored. The exchange in progress keeps its data and its edge count, and the transmit register keeps its value.
- R9: System bit 0 enables the host. While it is 0, `spi_cs_n` is 1 and transmit writes are ignored. While it is 1, `spi_cs_n` equals system bit 6, so writing 0 there asserts chip select.
- R10: While idle, SCK sits at CPOL and MOSI holds the last bit it drove. After an exchange, that bit is bit 0 of the byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; the side effects of a read take effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The embedded assertions check, on every cycle, the properties that hold regardless of data. SCK and MOSI stay still while the engine is idle. SCK starts each exchange at its rest level. The edge count never moves backwards, even when a transmit write arrives mid-exchange. Receive full is raised whenever busy falls, and an exchange starts only with the host enabled and after a bus write. Whether the bits come out in the right order, sampled on the right edge, at the right half-period for each mode and prescaler setting, can be shown only by the bench. It acts as an SPI device in all four modes across both prescalers and several divider values, and it checks the captured bytes, the edge spacing and the idle levels against values it computes itself.

// File: rtl/spih_pkg.sv
package spih_pkg;
   // byte offsets of the registers on the bus
   localparam int unsigned OFF_CTRL  = 'h00;
   localparam int unsigned OFF_STAT  = 'h04;
   localparam int unsigned OFF_SYS   = 'h08;
   localparam int unsigned OFF_TX    = 'h0C;
   localparam int unsigned OFF_RX    = 'h10;
   localparam int unsigned OFF_CTRL2 = 'h14;

   localparam int unsigned STAT_BUSY = 0;
   localparam int unsigned STAT_RXF  = 2;
   localparam int unsigned SYS_EN    = 0;
   localparam int unsigned SYS_CS    = 6;

   // control register layout, bit 7 down to bit 0
   typedef struct packed {
      logic       cpha;
      logic       cpol;
      logic       pre_hi;
      logic [4:0] div_n;
   } ctrl_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/spih_clkdiv.sv
module spih_clkdiv #(
   parameter int unsigned PRE_LO = 16,
   parameter int unsigned PRE_HI = 128,
   parameter int unsigned N_W    = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           pre_hi,
   input  logic [N_W-1:0] div_n,
   output logic           tick
);
   import spih_pkg::*;

   localparam int unsigned MAX_HALF = PRE_HI * (2 ** N_W);
   localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);
   localparam int unsigned SH_LO    = $clog2(PRE_LO);
   localparam int unsigned SH_HI    = $clog2(PRE_HI);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] steps;

   assign steps = CNT_W'(div_n) + CNT_W'(1);

   generate
      if (is_pow2(PRE_LO) && is_pow2(PRE_HI)) begin : g_shift
         always_comb limit = pre_hi ? (steps << SH_HI) : (steps << SH_LO);
      end else begin : g_mult
         always_comb limit = steps * (pre_hi ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO));
      end
   endgenerate

   assign tick = run && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

   // R3: the counter never runs past the programmed half-period
   a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && $stable(limit) |-> cnt_q < limit);
endmodule

// File: rtl/spih_shift.sv
module spih_shift #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] din,
   input  logic          cpol,
   input  logic          cpha,
   input  logic          tick,
   input  logic          miso,
   output logic          busy,
   output logic          sck,
   output logic          mosi,
   output logic          done,
   output logic [DW-1:0] dout
);
   localparam int unsigned EDGES = 2 * DW;
   localparam int unsigned EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

   logic          busy_q, sck_q, mosi_q;
   logic [EW-1:0] ecnt_q;
   logic [DW-1:0] tx_sr, rx_sr;
   logic          lead;

   assign lead = ~ecnt_q[0];
   assign done = busy_q && tick && (ecnt_q == LAST);
   assign dout = cpha ? {rx_sr[DW-2:0], miso} : rx_sr;
   assign busy = busy_q;
   assign sck  = sck_q;
   assign mosi = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         mosi_q <= 1'b0;
         ecnt_q <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
      end else if (!busy_q) begin
         sck_q <= cpol;
         if (start) begin
            busy_q <= 1'b1;
            ecnt_q <= '0;
            tx_sr  <= din;
            if (!cpha) mosi_q <= din[DW-1];
         end
      end else if (tick) begin
         sck_q  <= ~sck_q;
         ecnt_q <= ecnt_q + EW'(1);
         if (lead) begin
            if (cpha) begin
               mosi_q <= tx_sr[DW-1];
               tx_sr  <= tx_sr << 1;
            end else begin
               rx_sr <= {rx_sr[DW-2:0], miso};
            end
         end else begin
            if (cpha) begin
               rx_sr <= {rx_sr[DW-2:0], miso};
            end else if (ecnt_q != LAST) begin
               mosi_q <= tx_sr[DW-2];
               tx_sr  <= tx_sr << 1;
            end
         end
         if (ecnt_q == LAST) busy_q <= 1'b0;
      end
   end

   // R10: idle lines stay put
   a_r10_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && $past(!busy_q) && !$past(start) |-> $stable(mosi_q));
   a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && $past(!busy_q) && $past(!busy_q, 2) && $stable(cpol) && $past($stable(cpol))
      |-> $stable(sck_q));
   // R4: an exchange begins with SCK at its rest level
   a_r4_start_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> sck_q == $past(cpol));
   // R8: progress is never reset during an exchange
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> ecnt_q >= $past(ecnt_q));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned PRE_LO = 16,
   parameter int unsigned PRE_HI = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   import spih_pkg::*;

   localparam int unsigned DW  = 8;
   localparam int unsigned N_W = 5;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("spi_host_regs: ADDR_W must cover offset 0x14");
      end
      if (PRE_LO < 1 || PRE_HI <= PRE_LO) begin : g_bad_pre
         $error("spi_host_regs: need 1 <= PRE_LO < PRE_HI");
      end
   endgenerate

   ctrl_t         ctrl_q;
   logic [DW-1:0] sys_q, tx_q, rx_q;
   logic [31:0]   ctrl2_q;
   logic          rxf_q;

   logic hit_ctrl, hit_stat, hit_sys, hit_tx, hit_rx, hit_ctrl2;
   logic start, busy, tick, done;
   logic [DW-1:0] rx_byte;

   assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
   assign hit_stat  = (bus_addr == ADDR_W'(OFF_STAT));
   assign hit_sys   = (bus_addr == ADDR_W'(OFF_SYS));
   assign hit_tx    = (bus_addr == ADDR_W'(OFF_TX));
   assign hit_rx    = (bus_addr == ADDR_W'(OFF_RX));
   assign hit_ctrl2 = (bus_addr == ADDR_W'(OFF_CTRL2));

   assign start    = bus_wr && hit_tx && sys_q[SYS_EN] && !busy;
   assign spi_cs_n = !sys_q[SYS_EN] || sys_q[SYS_CS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         sys_q   <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         ctrl2_q <= '0;
         rxf_q   <= 1'b0;
      end else begin
         if (bus_wr && hit_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[DW-1:0]);
         if (bus_wr && hit_sys)   sys_q   <= bus_wdata[DW-1:0];
         if (bus_wr && hit_ctrl2) ctrl2_q <= bus_wdata;
         if (start)               tx_q    <= bus_wdata[DW-1:0];
         if (done) begin
            rx_q  <= rx_byte;
            rxf_q <= 1'b1;
         end else if (bus_rd && hit_rx) begin
            rxf_q <= 1'b0;
         end else if (bus_wr && hit_stat && !bus_wdata[STAT_RXF]) begin
            rxf_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)  bus_rdata = {24'd0, ctrl_q};
      if (hit_stat) begin
         bus_rdata[STAT_BUSY] = busy;
         bus_rdata[STAT_RXF]  = rxf_q;
      end
      if (hit_sys)   bus_rdata = {24'd0, sys_q};
      if (hit_tx)    bus_rdata = {24'd0, tx_q};
      if (hit_rx)    bus_rdata = {24'd0, rx_q};
      if (hit_ctrl2) bus_rdata = ctrl2_q;
   end

   spih_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .N_W(N_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .pre_hi (ctrl_q.pre_hi),
      .div_n  (ctrl_q.div_n),
      .tick   (tick)
   );

   spih_shift #(.DW(DW)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .din   (bus_wdata[DW-1:0]),
      .cpol  (ctrl_q.cpol),
      .cpha  (ctrl_q.cpha),
      .tick  (tick),
      .miso  (spi_miso),
      .busy  (busy),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .done  (done),
      .dout  (rx_byte)
   );

   // R7: end of exchange always leaves the receive-full flag up
   a_r7_full_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rxf_q);
   // R9: exchanges only start with the host enabled
   a_r9_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(sys_q[SYS_EN]));
   // R6: busy rises only after a bus write
   a_r6_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr));
endmodule

// File: tb/spi_host_regs_test.sv
module spi_host_regs_test;
   localparam int unsigned LO = 2;
   localparam int unsigned HI = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_cs_n;
   logic        spi_miso = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // device model state
   bit   mon_cpol = 1'b0, mon_cpha = 1'b0;
   int   half_exp = 1, last_edge = 0, edges = 0, gap_err = 0;
   logic [7:0] cap = '0, slv_sr = '0;
   logic prev_sck = 1'b0;

   spi_host_regs #(.ADDR_W(5), .PRE_LO(LO), .PRE_HI(HI)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (prev_sck !== spi_sck) begin
         bit lead, samp;
         if (cyc - last_edge != half_exp) gap_err++;
         last_edge = cyc;
         edges++;
         lead = (spi_sck != mon_cpol);
         samp = mon_cpha ? !lead : lead;
         if (samp) cap = {cap[6:0], spi_mosi};
         else if (mon_cpha) begin
            spi_miso = slv_sr[7];
            slv_sr = slv_sr << 1;
         end else begin
            slv_sr = slv_sr << 1;
            spi_miso = slv_sr[7];
         end
      end
      prev_sck = spi_sck;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic arm(input bit cpha, input bit cpol, input bit pre, input int n, input logic [7:0] pat);
      wr(5'h00, {24'd0, cpha, cpol, pre, 5'(n)});
      wr(5'h08, 32'h01);
      repeat (3) @(negedge clk);
      mon_cpol = cpol; mon_cpha = cpha;
      half_exp = (pre ? HI : LO) * (n + 1);
      edges = 0; gap_err = 0; cap = '0; slv_sr = pat;
      spi_miso = cpha ? 1'b0 : pat[7];
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 5000; k++) begin
         rd(5'h04, s);
         if (!s[0]) break;
      end
   endtask

   task automatic xfer(input bit cpha, input bit cpol, input bit pre, input int n,
                       input logic [7:0] d, input logic [7:0] pat);
      logic [31:0] s, r;
      arm(cpha, cpol, pre, n, pat);
      wr(5'h0C, {24'd0, d});
      last_edge = cyc;
      rd(5'h04, s);
      chk(s[0] == 1'b1, "R6 busy after write", s, 1);
      wait_idle();
      chk(edges == 16, "R5 edge count", edges, 16);
      chk(gap_err == 0, "R3 half-period", gap_err, 0);
      chk(cap == d, "R5/R4 MSB-first data on MOSI", cap, d);
      chk(spi_sck == cpol, "R10 SCK rests at CPOL", spi_sck, cpol);
      chk(spi_mosi == d[0], "R10 MOSI holds last bit", spi_mosi, d[0]);
      rd(5'h04, s);
      chk(s[2] == 1'b1, "R7 receive full set", s, 32'h4);
      rd(5'h10, r);
      chk(r == {24'd0, pat}, "R5 received byte", r, pat);
      rd(5'h04, s);
      chk(s[2] == 1'b0, "R7 cleared by receive read", s, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
      chk(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
      for (int a = 0; a < 6; a++) begin
         rd(5'(a * 4), v);
         chk(v == 0, "R1 register reset", v, 0);
      end
      // R2 map and readback
      wr(5'h00, 32'hABCD_12E7); rd(5'h00, v); chk(v == 32'hE7, "R2 control width", v, 32'hE7);
      wr(5'h14, 32'hDEAD_BEEF); rd(5'h14, v); chk(v == 32'hDEAD_BEEF, "R2 spare control", v, 32'hDEAD_BEEF);
      wr(5'h08, 32'h0000_0121); rd(5'h08, v); chk(v == 32'h21, "R2 system width", v, 32'h21);
      rd(5'h18, v); chk(v == 0, "R2 unmapped offset", v, 0);
      // R9 enable and chip select
      wr(5'h08, 32'h00); wr(5'h00, 32'h0);
      wr(5'h0C, 32'h5A);
      repeat (20) @(negedge clk);
      rd(5'h04, v); chk(v[0] == 1'b0, "R9 tx ignored when disabled", v, 0);
      rd(5'h0C, v); chk(v == 0, "R9 tx register unchanged", v, 0);
      chk(spi_cs_n == 1'b1, "R9 cs_n off when disabled", spi_cs_n, 1);
      wr(5'h08, 32'h41); chk(spi_cs_n == 1'b1, "R9 cs_n released", spi_cs_n, 1);
      wr(5'h08, 32'h01); chk(spi_cs_n == 1'b0, "R9 cs_n asserted", spi_cs_n, 0);
      // R3 R4 R5 sweep over modes, prescalers and divider values
      for (int m = 0; m < 4; m++)
         for (int p = 0; p < 2; p++)
            for (int j = 0; j < 4; j++) begin
               int n;
               logic [7:0] d;
               n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 5 : 31;
               d = 8'(m * 53 + p * 17 + n * 7 + 'hA5);
               xfer(m[1], m[0], p[0], n, d, ~d ^ 8'h3C);
            end
      // R8 write during an exchange is ignored
      arm(1'b0, 1'b1, 1'b0, 1, 8'h96);
      wr(5'h0C, 32'hC3);
      last_edge = cyc;
      repeat (10) @(negedge clk);
      wr(5'h0C, 32'h5A);
      wait_idle();
      chk(cap == 8'hC3, "R8 data kept", cap, 8'hC3);
      chk(edges == 16, "R8 edge count kept", edges, 16);
      chk(gap_err == 0, "R8 timing kept", gap_err, 0);
      rd(5'h0C, v); chk(v == 32'hC3, "R8 tx register kept", v, 32'hC3);
      // R7 clear through a status write, data kept
      wr(5'h04, 32'h0);
      rd(5'h04, v); chk(v[2] == 1'b0, "R7 cleared by status write", v, 0);
      rd(5'h10, v); chk(v == 32'h96, "R7 data kept after clear", v, 32'h96);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule